// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address. It walks a two-level translation table that sits in memory and checks the permissions of the access on the way. A request carries the virtual address and three flags: write or read, user or supervisor, and whether the access is an instruction fetch. The block also takes the upper bits of the directory base address and a paging-enable bit. With paging off, the address passes through untouched. With paging on, the walker fetches one directory entry. That entry either maps a 4MiB page directly or points to a second-level table of page entries.

Entries are read through a single-outstanding memory read port that uses valid/ready handshakes. An entry that passes its checks but has its accessed flag clear is written back with that flag set, through a separate write port. The answer is held on registered outputs and is marked by a one-cycle `done` pulse. The answer is either a physical address or a fault with an error word. On a fault, the faulting virtual address is also latched into a register that can be read.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, req_ready is 1. The outputs done, fault, fault_addr, rd_req_valid and wr_valid are all 0.
- R2: A request accepted while paging_en is 0 gives done on the following cycle, with paddr equal to req_vaddr and fault 0. No memory read or write is issued.
- R3: With paging on, the directory entry is read at {dir_frame, vaddr[31:22], 2'b00}. A page entry is read at {entry[31:12], vaddr[21:12], 2'b00}, using the directory entry's frame bits. A successful 4KiB translation gives paddr = {page_entry[31:12], vaddr[11:0]}, after exactly two reads.
- R4: A directory entry with bit 7 (page size) set maps a 4MiB page, provided it is present and permitted. Then paddr = {dir_entry[31:22], vaddr[21:0]}, after exactly one read. Bits 21:12 of that entry are ignored.
- R5: A directory entry with bit 0 (present) clear ends the walk with a fault after one read. No page entry is read and no write is issued.
- R6: At either level, an entry faults in any of three cases: bit 0 is clear, the access is a write and bit 1 (writable) is 0, or req_user is 1 and bit 2 (user allowed) is 0. A fault at the directory level stops the walk.
- R7: On a fault, the fault_code bits are set as follows, and paddr is 0:
  - bit 0 copies the present bit of the faulting entry;
  - bit 1 is the write flag;
  - bit 2 is the user flag;
  - bit 3 is 0;
  - bit 4 is the fetch flag.
  When the walk succeeds, fault is 0 and fault_code is 0.
- R8: fault_addr takes the virtual address of a faulting request in the cycle that done is high. It keeps its value through walks that do not fault.
- R9: An entry that passes its checks with bit 5 (accessed) clear is written back once, before the walk goes on. The write goes to the address it was read from, with bit 5 set and every other bit unchanged. Entries that already have bit 5 set, and entries that fault, are not written.
- R10: Each accepted request gives exactly one done pulse, one cycle wide. req_ready is 1 only while idle. rd_req_valid with rd_addr, and wr_valid with wr_addr and wr_data, hold steady until their ready is seen.
- R11: Stalls on rd_req_ready and wr_ready change only timing. Results and memory contents match the unstalled case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | ADDR_W | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| req_fetch | input | 1 | 1 for an instruction fetch (reported in the error word only) |
| paging_en | input | 1 | Translation enable; 0 passes the address through |
| dir_frame | input | ADDR_W-OFF_W | Upper bits of the directory's physical address (low bits are zero) |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | ADDR_W | Byte address of the entry to read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | ADDR_W | Entry word returned |
| wr_valid | output | 1 | Accessed-flag write-back request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Byte address of the entry written back |
| wr_data | output | ADDR_W | Entry word with the accessed flag set |
| done | output | 1 | One-cycle result strobe |
| paddr | output | ADDR_W | Physical address (0 on a fault) |
| fault | output | 1 | The result is a page fault |
| fault_code | output | 5 | Fault error word |
| fault_addr | output | ADDR_W | Virtual address of the most recent fault |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 10-bit index and a 12-bit offset, with 4MiB pages enabled. The directory sits at physical address 0 and a single page table sits at 0x1000, so a 2048-word memory model holds every entry the bench touches. Directory entries are swept over 32 flag patterns (present, writable, user, accessed, page size), page entries over 16 patterns, and accesses over all 8 combinations of write, user and fetch. This reaches every fault cause at both levels, every error-word bit, both writeback cases and both page sizes. A second pass repeats part of the sweep with the read and write ready signals toggling, to show that stalls alter nothing but timing.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_REQ,
      S_RD_WAIT,
      S_CHECK,
      S_WR_ACC,
      S_DONE
   } walk_st_t;

   // entry flag positions
   localparam int unsigned FLG_PRESENT  = 0;
   localparam int unsigned FLG_WRITE    = 1;
   localparam int unsigned FLG_USER     = 2;
   localparam int unsigned FLG_ACCESSED = 5;
   localparam int unsigned FLG_LARGE    = 7;

   // fault error word positions
   localparam int unsigned EC_PRESENT = 0;
   localparam int unsigned EC_WRITE   = 1;
   localparam int unsigned EC_USER    = 2;
   localparam int unsigned EC_RSVD    = 3;
   localparam int unsigned EC_FETCH   = 4;
   localparam int unsigned EC_W       = 5;

endpackage

// File: rtl/pgw_check.sv
module pgw_check
   import pgw_pkg::*;
(
   input  logic            present,
   input  logic            rw,
   input  logic            us,
   input  logic            is_wr,
   input  logic            is_usr,
   input  logic            is_fetch,
   output logic            deny,
   output logic [EC_W-1:0] code
);

   always_comb begin
      deny = !present || (is_wr && !rw) || (is_usr && !us);
   end

   always_comb begin
      code             = '0;
      code[EC_PRESENT] = present;
      code[EC_WRITE]   = is_wr;
      code[EC_USER]    = is_usr;
      code[EC_RSVD]    = 1'b0;
      code[EC_FETCH]   = is_fetch;
   end

endmodule

// File: rtl/pgw_addr.sv
module pgw_addr
   import pgw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic                    lvl,
   input  logic [ADDR_W-OFF_W-1:0] base_frm,
   input  logic [ADDR_W-OFF_W-1:0] tbl_frm,
   input  logic [ADDR_W-1:0]       va,
   input  logic [ADDR_W-OFF_W-1:0] ent_frm,
   output logic [ADDR_W-1:0]       ent_addr,
   output logic [ADDR_W-1:0]       pa_small,
   output logic [ADDR_W-1:0]       pa_large
);

   localparam int unsigned FRM_W  = ADDR_W - OFF_W;
   localparam int unsigned LOFF_W = IDX_W + OFF_W;
   localparam int unsigned HI_W   = ADDR_W - LOFF_W;

   logic [IDX_W-1:0] dir_idx;
   logic [IDX_W-1:0] tbl_idx;

   assign dir_idx  = va[ADDR_W-1 -: IDX_W];
   assign tbl_idx  = va[LOFF_W-1 -: IDX_W];
   assign ent_addr = lvl ? {tbl_frm, tbl_idx, 2'b00} : {base_frm, dir_idx, 2'b00};
   assign pa_small = {ent_frm, va[OFF_W-1:0]};

   generate
      if (LARGE_EN) begin : g_large
         assign pa_large = {ent_frm[FRM_W-1 -: HI_W], va[LOFF_W-1:0]};
      end else begin : g_no_large
         assign pa_large = '0;
      end
   endgenerate

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ADDR_W-1:0]       req_vaddr,
   input  logic                    req_write,
   input  logic                    req_user,
   input  logic                    req_fetch,
   input  logic                    paging_en,
   input  logic [ADDR_W-OFF_W-1:0] dir_frame,
   output logic                    rd_req_valid,
   input  logic                    rd_req_ready,
   output logic [ADDR_W-1:0]       rd_addr,
   input  logic                    rd_rsp_valid,
   input  logic [ADDR_W-1:0]       rd_rsp_data,
   output logic                    wr_valid,
   input  logic                    wr_ready,
   output logic [ADDR_W-1:0]       wr_addr,
   output logic [ADDR_W-1:0]       wr_data,
   output logic                    done,
   output logic [ADDR_W-1:0]       paddr,
   output logic                    fault,
   output logic [EC_W-1:0]         fault_code,
   output logic [ADDR_W-1:0]       fault_addr
);

   localparam int unsigned FRM_W = ADDR_W - OFF_W;

   // elaboration-time parameter checks
   generate
      if (ADDR_W != 2 * IDX_W + OFF_W) begin : g_bad_split
         $error("address must split into two indices and an offset");
      end
      if (OFF_W != IDX_W + 2) begin : g_bad_table
         $error("a table of word entries must fill exactly one frame");
      end
      if (OFF_W < 8) begin : g_bad_flags
         $error("offset too narrow to hold the entry flags");
      end
   endgenerate

   walk_st_t          st;
   logic              lvl;
   logic [ADDR_W-1:0] va_q;
   logic [ADDR_W-1:0] ent_q;
   logic [ADDR_W-1:0] paddr_q;
   logic [ADDR_W-1:0] faddr_q;
   logic              wr_q, usr_q, fet_q;
   logic [FRM_W-1:0]  base_q;
   logic [FRM_W-1:0]  tbl_q;
   logic              fault_q;
   logic [EC_W-1:0]   code_q;

   logic [ADDR_W-1:0] ent_addr;
   logic [ADDR_W-1:0] pa_small;
   logic [ADDR_W-1:0] pa_large;
   logic              is_large;
   logic              deny;
   logic [EC_W-1:0]   code_c;
   logic              do_adv;

   pgw_addr #(
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .OFF_W   (OFF_W),
      .LARGE_EN(LARGE_EN)
   ) u_addr (
      .lvl     (lvl),
      .base_frm(base_q),
      .tbl_frm (tbl_q),
      .va      (va_q),
      .ent_frm (ent_q[ADDR_W-1 -: FRM_W]),
      .ent_addr(ent_addr),
      .pa_small(pa_small),
      .pa_large(pa_large)
   );

   pgw_check u_chk (
      .present (ent_q[FLG_PRESENT]),
      .rw      (ent_q[FLG_WRITE]),
      .us      (ent_q[FLG_USER]),
      .is_wr   (wr_q),
      .is_usr  (usr_q),
      .is_fetch(fet_q),
      .deny    (deny),
      .code    (code_c)
   );

   generate
      if (LARGE_EN) begin : g_lp
         assign is_large = ent_q[FLG_LARGE];
      end else begin : g_np
         assign is_large = 1'b0;
      end
   endgenerate

   // move past the current entry: after a clean check, or once its write-back is taken
   assign do_adv = (st == S_CHECK && !deny && ent_q[FLG_ACCESSED]) ||
                   (st == S_WR_ACC && wr_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         lvl     <= 1'b0;
         va_q    <= '0;
         ent_q   <= '0;
         paddr_q <= '0;
         faddr_q <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         fet_q   <= 1'b0;
         base_q  <= '0;
         tbl_q   <= '0;
         fault_q <= 1'b0;
         code_q  <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  wr_q   <= req_write;
                  usr_q  <= req_user;
                  fet_q  <= req_fetch;
                  base_q <= dir_frame;
                  lvl    <= 1'b0;
                  if (paging_en) begin
                     st <= S_RD_REQ;
                  end else begin
                     paddr_q <= req_vaddr;
                     fault_q <= 1'b0;
                     code_q  <= '0;
                     st      <= S_DONE;
                  end
               end
            end
            S_RD_REQ: begin
               if (rd_req_ready) st <= S_RD_WAIT;
            end
            S_RD_WAIT: begin
               if (rd_rsp_valid) begin
                  ent_q <= rd_rsp_data;
                  st    <= S_CHECK;
               end
            end
            S_CHECK: begin
               if (deny) begin
                  fault_q <= 1'b1;
                  code_q  <= code_c;
                  faddr_q <= va_q;
                  paddr_q <= '0;
                  st      <= S_DONE;
               end else if (!ent_q[FLG_ACCESSED]) begin
                  st <= S_WR_ACC;
               end
            end
            S_WR_ACC: begin
            end
            S_DONE: begin
               st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase

         if (do_adv) begin
            if (lvl) begin
               paddr_q <= pa_small;
               fault_q <= 1'b0;
               code_q  <= '0;
               st      <= S_DONE;
            end else if (is_large) begin
               paddr_q <= pa_large;
               fault_q <= 1'b0;
               code_q  <= '0;
               st      <= S_DONE;
            end else begin
               lvl   <= 1'b1;
               tbl_q <= ent_q[ADDR_W-1 -: FRM_W];
               st    <= S_RD_REQ;
            end
         end
      end
   end

   assign req_ready    = (st == S_IDLE);
   assign done         = (st == S_DONE);
   assign rd_req_valid = (st == S_RD_REQ);
   assign rd_addr      = ent_addr;
   assign wr_valid     = (st == S_WR_ACC);
   assign wr_addr      = ent_addr;
   assign wr_data      = ent_q | (ADDR_W'(1) << FLG_ACCESSED);
   assign paddr        = paddr_q;
   assign fault        = fault_q;
   assign fault_code   = code_q;
   assign fault_addr   = faddr_q;

   // ---------------- assertions ----------------
   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

   p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !paging_en |=> done && !fault && paddr == $past(req_vaddr));

   p_faddr_only_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fault_addr) |-> done && fault);

   p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault |-> paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

   p_absent_dir_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_CHECK && !lvl && !ent_q[FLG_PRESENT] |=> done && fault && !rd_req_valid);

   p_fault_zero_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> paddr == '0 && !fault_code[EC_RSVD]);

endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        req_fetch = 1'b0;
   logic        paging_en = 1'b0;
   logic [19:0] dir_frame = '0;
   logic        rd_req_valid;
   logic        rd_req_ready;
   logic [31:0] rd_addr;
   logic        rd_rsp_valid;
   logic [31:0] rd_rsp_data;
   logic        wr_valid;
   logic        wr_ready;
   logic [31:0] wr_addr;
   logic [31:0] wr_data;
   logic        done;
   logic [31:0] paddr;
   logic        fault;
   logic [4:0]  fault_code;
   logic [31:0] fault_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgwalk_top u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
      .paging_en(paging_en), .dir_frame(dir_frame),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .paddr(paddr), .fault(fault), .fault_code(fault_code),
      .fault_addr(fault_addr)
   );

   // ---------------- memory model ----------------
   logic [31:0] mem [0:2047];
   logic        set_en = 1'b0;
   logic [10:0] set_idx = '0;
   logic [31:0] set_data = '0;
   logic        cnt_clr = 1'b0;
   logic        slow = 1'b0;
   logic [7:0]  tick = '0;
   int          n_rd = 0;
   int          n_wr = 0;
   int          n_badaddr = 0;
   logic        rsp_v = 1'b0;
   logic [31:0] rsp_d = '0;

   assign rd_req_ready = !(slow && tick[0]);
   assign wr_ready     = !(slow && tick[1]);
   assign rd_rsp_valid = rsp_v;
   assign rd_rsp_data  = rsp_d;

   always @(posedge clk) begin
      tick  <= tick + 8'd1;
      rsp_v <= 1'b0;
      if (set_en) mem[set_idx] <= set_data;
      if (cnt_clr) begin
         n_rd <= 0;
         n_wr <= 0;
      end
      if (rd_req_valid && rd_req_ready) begin
         rsp_v <= 1'b1;
         n_rd  <= n_rd + 1;
         if (rd_addr[31:13] == 19'd0 && rd_addr[1:0] == 2'd0) rsp_d <= mem[rd_addr[12:2]];
         else begin
            rsp_d     <= '0;
            n_badaddr <= n_badaddr + 1;
         end
      end
      if (wr_valid && wr_ready) begin
         n_wr <= n_wr + 1;
         if (wr_addr[31:13] == 19'd0 && wr_addr[1:0] == 2'd0) mem[wr_addr[12:2]] <= wr_data;
         else n_badaddr <= n_badaddr + 1;
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_faddr = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [10:0] idx, input logic [31:0] data);
      @(negedge clk);
      set_en   = 1'b1;
      set_idx  = idx;
      set_data = data;
      @(negedge clk);
      set_en   = 1'b0;
   endtask

   function automatic logic [31:0] mk_dir(input int d);
      logic [4:0]  b;
      logic [31:0] e;
      b     = 5'(d);
      e     = '0;
      e[0]  = b[0];
      e[1]  = b[1];
      e[2]  = b[2];
      e[3]  = b[1] ^ b[2];
      e[4]  = b[0];
      e[5]  = b[3];
      e[7]  = b[4];
      if (b[4]) e[31:12] = {10'(d + 100), 10'(d * 3)};
      else      e[31:12] = 20'h00001;
      return e;
   endfunction

   function automatic logic [31:0] mk_pg(input int p);
      logic [3:0]  b;
      logic [31:0] e;
      b        = 4'(p);
      e        = '0;
      e[0]     = b[0];
      e[1]     = b[1];
      e[2]     = b[2];
      e[3]     = b[0];
      e[5]     = b[3];
      e[8]     = 1'b1;
      e[31:12] = 20'(p * 7 + 'h123);
      return e;
   endfunction

   // run one request and capture its result; returns cycles from accept to done
   logic [31:0] r_pa;
   logic        r_flt;
   logic [4:0]  r_code;
   int          r_lat;

   task automatic walk(input logic [31:0] va, input logic w, input logic u,
                       input logic f, input logic pen);
      bit got;
      @(negedge clk);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
      req_vaddr = va;
      req_write = w;
      req_user  = u;
      req_fetch = f;
      paging_en = pen;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      got   = 1'b0;
      r_lat = 0;
      for (int k = 0; k < 200 && !got; k++) begin
         if (done) got = 1'b1;
         else begin
            r_lat++;
            @(negedge clk);
         end
      end
      chk(got, "R10 done seen", 32'(got), 32'd1);
      r_pa   = paddr;
      r_flt  = fault;
      r_code = fault_code;
      chk(fault_addr == exp_faddr, "R8 fault_addr", fault_addr, exp_faddr);
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
   endtask

   task automatic run_case(input int d, input int p, input int m, input bit stalled);
      logic [31:0] va, de, pe, exp_de, exp_pe, exp_pa;
      logic        w, u, f, exp_flt;
      logic [4:0]  exp_code;
      int          exp_rd, exp_wr;
      string       t_pa;
      w  = m[0];
      u  = m[1];
      f  = m[2];
      va = {10'(d), 10'(p), 12'(d * 37 + p * 11 + m * 5)};
      de = mk_dir(d);
      pe = mk_pg(p);
      poke(11'(d), de);
      poke(11'(1024 + p), pe);
      exp_de = de;
      exp_pe = pe;
      exp_wr = 0;
      exp_flt = 1'b0;
      exp_code = '0;
      exp_pa = '0;
      if (!de[0] || (w && !de[1]) || (u && !de[2])) begin
         exp_flt  = 1'b1;
         exp_code = {f, 1'b0, u, w, de[0]};
         exp_rd   = 1;
         t_pa     = de[0] ? "R6 dir deny" : "R5 dir absent";
      end else begin
         if (!de[5]) exp_wr++;
         exp_de = de | 32'h20;
         if (de[7]) begin
            exp_pa = {de[31:22], va[21:0]};
            exp_rd = 1;
            t_pa   = "R4 large page";
         end else begin
            exp_rd = 2;
            if (!pe[0] || (w && !pe[1]) || (u && !pe[2])) begin
               exp_flt  = 1'b1;
               exp_code = {f, 1'b0, u, w, pe[0]};
               t_pa     = "R6 page deny";
            end else begin
               if (!pe[5]) exp_wr++;
               exp_pe = pe | 32'h20;
               exp_pa = {pe[31:12], va[11:0]};
               t_pa   = "R3 small page";
            end
         end
      end
      if (exp_flt) exp_faddr = va;
      if (stalled) t_pa = {"R11 stalled ", t_pa};
      walk(va, w, u, f, 1'b1);
      chk(r_flt == exp_flt, t_pa, 32'(r_flt), 32'(exp_flt));
      chk(r_pa == exp_pa, t_pa, r_pa, exp_pa);
      chk(r_code == exp_code, "R7 fault code", 32'(r_code), 32'(exp_code));
      chk(n_rd == exp_rd, "R5 R3 R4 read count", 32'(n_rd), 32'(exp_rd));
      chk(n_wr == exp_wr, "R9 write count", 32'(n_wr), 32'(exp_wr));
      chk(mem[11'(d)] == exp_de, "R9 dir entry after walk", mem[11'(d)], exp_de);
      chk(mem[11'(1024 + p)] == exp_pe, "R9 page entry after walk", mem[11'(1024 + p)], exp_pe);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
      chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
      chk(fault == 1'b0, "R1 fault", 32'(fault), 32'd0);
      chk(fault_addr == 32'd0, "R1 fault_addr", fault_addr, 32'd0);
      chk(rd_req_valid == 1'b0 && wr_valid == 1'b0, "R1 no memory request",
          32'({rd_req_valid, wr_valid}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0, "R1 idle after release",
          32'({req_ready, done}), 32'h2);

      // R2 pass-through with paging off
      for (int i = 0; i < 6; i++) begin
         logic [31:0] va;
         va = 32'h1357_9bdf * (i + 1) + 32'h0f0f_0000 * i;
         walk(va, i[0], i[1], i[2], 1'b0);
         chk(r_pa == va, "R2 bypass paddr", r_pa, va);
         chk(r_flt == 1'b0, "R2 bypass fault", 32'(r_flt), 32'd0);
         chk(r_lat == 0, "R2 bypass latency", 32'(r_lat), 32'd0);
         chk(n_rd == 0 && n_wr == 0, "R2 bypass no memory", 32'(n_rd + n_wr), 32'd0);
      end

      // main sweep: directory patterns x page patterns x access kinds
      dir_frame = 20'h00000;
      for (int d = 0; d < 32; d++)
         for (int p = 0; p < 16; p++)
            for (int m = 0; m < 8; m++)
               run_case(d, p, m, 1'b0);

      // stalled sweep on both ports
      slow = 1'b1;
      for (int d = 0; d < 32; d++)
         for (int p = 0; p < 16; p += 5)
            run_case(d, p, (d + p) % 8, 1'b1);
      slow = 1'b0;

      chk(n_badaddr == 0, "R3 entry addresses in range", 32'(n_badaddr), 32'd0);
      summary();
      $finish;
   end

endmodule